// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs an 8-bit successive-approximation search against an external comparator. A bus master starts a conversion by pulling the active-low chip-select and write strobes low together. The block then resolves the code from the most significant bit down to the least, one bit per internal step. It shows each trial code to the DAC and, at the end, raises a one-cycle done strobe together with the final code.

The internal step rate is the external clock divided by eight, and a free-running divider provides it. While both strobes are low the block sits in a start-hold condition with the trial code forced to zero. The start flag is released only on a divider terminal count after the strobes have gone away, so strobes of any width are accepted. Conversion then begins between 1 and 8 clocks after the release. A start request issued mid-conversion discards the search in progress.

The control state machine has three states. `ST_IDLE` has no conversion running. `ST_HOLD` means the start flag is set and the search is held cleared. `ST_CONVERT` means bits are being resolved. Its named transitions are:
- T_START: any state to `ST_HOLD`, when both strobes are low.
- T_LAUNCH: `ST_HOLD` to `ST_CONVERT`, on a terminal count with the strobes released.
- T_FINISH: `ST_CONVERT` to `ST_IDLE`, when the least significant bit is resolved.

Top module: `sar_start_seq`

## Requirements
- R1: Bits are resolved most significant first. At each step the bit under test is kept as 1 when `cmp_ge` is 1 (input at or above the trial code) and cleared when `cmp_ge` is 0. With a comparator that reports `vin >= trial_code`, the final code equals `vin`.
- R2: Each step lasts exactly 8 clocks, and `trial_code` changes only at a step boundary or on a start request. `done` rises exactly 64 clocks after the trial code first shows 0x80. After j steps (j = 0..7) the trial code is the decided upper bits of the code with bit 7-j set and all lower bits clear.
- R3: While `cs_n` and `wr_n` are both low, from the first clock edge that samples them low, `trial_code` is 0 and `done` stays 0.
- R4: The start flag clears only on a divider terminal count. Terminal counts fall on every eighth clock edge after reset release, at edge numbers 8, 16, 24 and so on. Conversion begins at the first terminal count whose edge samples both strobes no longer low together, which is 1 to 8 clocks after release.
- R5: A start request during a conversion aborts it without a done strobe. This holds even when the request lands on the same edge that would have completed the conversion; `result` then keeps its previous value.
- R6: Only one strobe low (the other high) has no effect. `trial_code` stays unchanged and no `done` appears.
- R7: `done` is high for exactly one clock per completed conversion. `result` holds the final code from that strobe until the next completion.
- R8: Full scale gives 0xFF and a zero input gives 0x00.
- R9: After reset `trial_code`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write (start) strobe |
| cmp_ge | input | 1 | Comparator decision: 1 when input is at or above `trial_code` |
| trial_code | output | 8 | Current trial code driven to the DAC |
| done | output | 1 | One-cycle completion strobe |
| result | output | 8 | Final code, updated with `done` |

## Verification
Two events can land on the same clock edge: a fresh start request and the resolution of the last bit. The bench counts 63 clocks after the trial code first reads 0x80 and then pulls both strobes low, so the request is sampled on exactly the completing edge. The start must win. `done` must stay low, the trial code must read zero, and `result` must keep the earlier conversion's value. A clean conversion afterwards shows that the block recovers.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // Control states of the conversion sequencer
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sar_step_div.sv
// Free-running divider: one tick every DIV_RATIO clocks, never reset by a start.
module sar_step_div #(
    parameter int DIV_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == CNT_LAST);

    // R2: ticks are isolated, one per divider period
    a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sar_start_flag.sv
// Start flag: set by the strobe pair, cleared only by a tick once the strobes are gone.
module sar_start_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tick,
    output logic start_q,
    output logic launch
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else if (req) begin
            start_q <= 1'b1;
        end else if (tick) begin
            start_q <= 1'b0;
        end
    end

    assign launch = start_q && tick && !req;

    // R3: a sampled request always leaves the flag set
    a_r3_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> start_q);

    // R4: the flag drops only on a tick with the request gone
    a_r4_flag_clears_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_q) |-> ($past(tick) && !$past(req)));

endmodule

// File: rtl/sar_bit_ring.sv
// One-hot ring selecting the bit under test, walking from MSB to LSB.
module sar_bit_ring #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              shift,
    output logic [CODE_W-1:0] ring
);
    localparam logic [CODE_W-1:0] RING_MSB = {1'b1, {(CODE_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring <= '0;
        end else if (clr) begin
            ring <= '0;
        end else if (load) begin
            ring <= RING_MSB;
        end else if (shift) begin
            ring <= ring >> 1;
        end
    end

    // R1: at most one bit position is under test
    a_r1_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring));

endmodule

// File: rtl/sar_approx_reg.sv
// Successive-approximation register: per-bit decide-and-advance logic.
module sar_approx_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              step,
    input  logic [CODE_W-1:0] ring,
    input  logic              cmp_ge,
    output logic [CODE_W-1:0] code
);
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        if (i == CODE_W - 1) begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    code[i] <= 1'b0;
                end else if (clr) begin
                    code[i] <= 1'b0;
                end else if (load) begin
                    code[i] <= 1'b1;
                end else if (step && ring[i]) begin
                    code[i] <= cmp_ge;
                end
            end
        end else begin : g_low
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    code[i] <= 1'b0;
                end else if (clr || load) begin
                    code[i] <= 1'b0;
                end else if (step && ring[i]) begin
                    code[i] <= cmp_ge;
                end else if (step && ring[i+1]) begin
                    code[i] <= 1'b1;
                end
            end
        end
    end

    // R3: a clear leaves an all-zero trial code
    a_r3_code_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code == '0));

endmodule

// File: rtl/sar_start_seq.sv
// Top: control state machine tying divider, start flag, ring and SAR together.
module sar_start_seq
    import sar_seq_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int DIV_RATIO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              cmp_ge,
    output logic [CODE_W-1:0] trial_code,
    output logic              done,
    output logic [CODE_W-1:0] result
);
    seq_state_t        state_q;
    seq_state_t        state_d;
    logic              req;
    logic              tick;
    logic              start_q;
    logic              launch;
    logic              step;
    logic              finish;
    logic [CODE_W-1:0] ring;
    logic [CODE_W-1:0] code;
    logic              done_q;
    logic [CODE_W-1:0] result_q;

    assign req = !cs_n && !wr_n;

    sar_step_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sar_start_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .tick    (tick),
        .start_q (start_q),
        .launch  (launch)
    );

    assign step   = (state_q == ST_CONVERT) && tick && !req;
    assign finish = step && ring[0];

    sar_bit_ring #(.CODE_W(CODE_W)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (req),
        .load  (launch),
        .shift (step),
        .ring  (ring)
    );

    sar_approx_reg #(.CODE_W(CODE_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (req),
        .load   (launch),
        .step   (step),
        .ring   (ring),
        .cmp_ge (cmp_ge),
        .code   (code)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_START overrides, then T_LAUNCH / T_FINISH
    always_comb begin
        state_d = state_q;
        if (req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_HOLD:    if (launch) state_d = ST_CONVERT;
                ST_CONVERT: if (finish) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs: completion strobe and held result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= finish;
            if (finish) begin
                result_q <= {code[CODE_W-1:1], cmp_ge};
            end
        end
    end

    assign trial_code = code;
    assign done       = done_q;
    assign result     = result_q;

    // R4: the hold state mirrors the start flag
    a_r4_hold_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) == start_q);

    // R5: a sampled start never yields a completion strobe
    a_r5_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !done);

    // R7: completion is a single-cycle strobe
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the trial code moves only at a step boundary or on a start
    a_r2_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_code != $past(trial_code)) |-> ($past(tick) || $past(req)));

endmodule

// File: tb/sar_start_seq_bench.sv
module sar_start_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n  = 1'b1;
    logic       wr_n  = 1'b1;
    logic [7:0] vin   = 8'h00;
    logic       cmp_ge;
    logic [7:0] trial_code;
    logic       done;
    logic [7:0] result;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit ended  = 1'b0;

    assign cmp_ge = (vin >= trial_code);

    sar_start_seq u_sar_start_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .cmp_ge     (cmp_ge),
        .trial_code (trial_code),
        .done       (done),
        .result     (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Releases held strobes, then follows one full conversion of v
    task automatic release_and_convert(input logic [7:0] v, input string tag);
        int rel_cyc;
        int exp_wait;
        int waited;
        int early;
        int mask;
        int exp_trial;
        vin = v;
        @(negedge clk);
        cs_n = 1'b1;
        wr_n = 1'b1;
        rel_cyc  = cyc;
        exp_wait = ((rel_cyc + 8) / 8) * 8 - rel_cyc;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (trial_code != 8'h80 && waited < 20);
        check(waited == exp_wait, "R4 start latency exact", waited, exp_wait);
        check(waited >= 1 && waited <= 8, "R4 start latency range", waited, 8);
        early = 0;
        for (int k = 0; k < 64; k++) begin
            if (k % 8 == 0) begin
                mask      = 256 - (1 << (8 - k/8));
                exp_trial = (int'(v) & mask) | (1 << (7 - k/8));
                check(trial_code == 8'(exp_trial), "R2 R1 trial step", trial_code, exp_trial);
            end
            if (done) early++;
            @(negedge clk);
        end
        check(early == 0, "R2 no early done", early, 0);
        check(done == 1'b1, "R2 done at 64 clocks", done, 1);
        check(result == v, tag, result, v);
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", done, 0);
        check(result == v, "R7 result held", result, v);
    endtask

    task automatic convert(input logic [7:0] v, input string tag);
        @(negedge clk);
        cs_n = 1'b0;
        wr_n = 1'b0;
        release_and_convert(v, tag);
    endtask

    task automatic t_reset_state();
        check(trial_code == 8'h00, "R9 trial after reset", trial_code, 0);
        check(done == 1'b0, "R9 done after reset", done, 0);
        check(result == 8'h00, "R9 result after reset", result, 0);
    endtask

    task automatic t_wide_strobe();
        int bad;
        bad = 0;
        @(negedge clk);
        cs_n = 1'b0;
        wr_n = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (trial_code != 8'h00 || done) bad++;
        end
        check(bad == 0, "R3 held in reset by wide strobe", bad, 0);
        release_and_convert(8'h5A, "R1 result after wide strobe");
    endtask

    task automatic t_abort();
        int bad;
        bad = 0;
        vin = 8'h3C;
        @(negedge clk);
        cs_n = 1'b0;
        wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        wr_n = 1'b1;
        repeat (30) @(negedge clk);
        cs_n = 1'b0;
        wr_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (trial_code != 8'h00 || done) bad++;
        end
        check(bad == 0, "R5 abort clears search", bad, 0);
        release_and_convert(8'hA5, "R5 result after abort");
    endtask

    task automatic t_collide();
        logic [7:0] prev;
        int waited;
        prev = result;
        vin  = 8'h77;
        @(negedge clk);
        cs_n = 1'b0;
        wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        wr_n = 1'b1;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (trial_code != 8'h80 && waited < 20);
        repeat (63) @(negedge clk);
        cs_n = 1'b0;
        wr_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R5 start beats completion done", done, 0);
        check(trial_code == 8'h00, "R5 start beats completion trial", trial_code, 0);
        check(result == prev, "R5 result kept on collision", result, prev);
        release_and_convert(8'hC3, "R5 result after collision");
    endtask

    task automatic t_single_strobe();
        logic [7:0] t0;
        logic [7:0] r0;
        int bad;
        bad = 0;
        t0 = trial_code;
        r0 = result;
        vin = 8'h12;
        @(negedge clk);
        cs_n = 1'b1;
        wr_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (trial_code != t0 || done) bad++;
        end
        cs_n = 1'b0;
        wr_n = 1'b1;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (trial_code != t0 || done) bad++;
        end
        cs_n = 1'b1;
        check(bad == 0, "R6 single strobe ignored", bad, 0);
        check(result == r0, "R6 result unchanged", result, r0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        convert(8'hB6, "R1 result B6");
        convert(8'hFF, "R8 full scale");
        convert(8'h00, "R8 zero input");
        convert(8'h01, "R1 result 01");
        t_wide_strobe();
        t_abort();
        t_collide();
        t_single_strobe();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule